// File: doc/BRIEF.md
# Vector Widen/Narrow Operand Legality Checker

This block judges whether a vector widening or narrowing instruction may issue. It looks only at the register operands and the current vector configuration. It does not look at the opcode or the element data. The inputs are:
- the destination and two source register numbers;
- the mask-enable bit;
- the register-group multiplier, given as a log2 code;
- the element-width code;
- a flag that says the vector unit is enabled;
- an operand-class select;
- a flag that says whether the first source is a vector register.

A decode stage presents one candidate per cycle with `inValid`. One cycle later the block returns `outValid` together with `outIllegal`.

Three operand classes are supported:
- **Class 0:** a double-width destination fed by two single-width sources.
- **Class 1:** a double-width destination and a double-width second source, with a single-width first source.
- **Class 2:** a single-width destination fed by a double-width second source.

The checks cover register-group alignment, overlap between groups of unequal size, and exclusion of register 0 when it carries the mask. A group is always a contiguous run of registers that starts at the given register number.

Top module: `vwn_legality_check`

## Requirements
- R1: In every class the result is illegal when any of these holds: `unitOn` is 0; `lmulLog2` is 3 (a multiplier of 8); or twice the element width exceeds the ELEN parameter (default 64). `sewCode` 0, 1, 2, 3 means 8, 16, 32, 64 bits.
- R2: `outValid` is 1 exactly one cycle after `inValid` was 1. `outIllegal` is 0 whenever `outValid` is 0. A synchronous active-high reset clears both outputs.
- R3: In classes 0 and 1, `rdIdx` must be a multiple of 2·L, where L = 1 << `lmulLog2`.
- R4: In classes 0 and 1, when `unmasked` is 0, `rdIdx` must not be 0.
- R5: In class 0, the destination group of 2·L registers must not overlap the `rs2Idx` group of L registers. `rs2Idx` must also be a multiple of L.
- R6: In class 0 with `vs1IsVec` set, `rs1Idx` must be a multiple of L, and its L-register group must not overlap the destination group. When `vs1IsVec` is 0, `rs1Idx` is not checked.
- R7: In class 1, `rs2Idx` must be a multiple of 2·L. The `rs2Idx` group may coincide with the destination group. With `vs1IsVec` set, `rs1Idx` must be a multiple of L and its L-register group must not overlap the destination group.
- R8: In class 2, `rs2Idx` must be a multiple of 2·L and `rdIdx` a multiple of L. When `unmasked` is 0 and L > 1, `rdIdx` must not be 0.
- R9: In class 2, the L-register destination group must not overlap the 2·L-register `rs2Idx` group. With `vs1IsVec` set, `rs1Idx` must be a multiple of L.
- R10: `opClass` value 3 is always illegal.
- R11: Group bounds are evaluated without wrapping. A group that ends at register 32 still overlaps a group that also ends at register 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Candidate present this cycle |
| rdIdx | input | 5 | Destination register number |
| rs1Idx | input | 5 | First source register number |
| rs2Idx | input | 5 | Second source register number |
| unmasked | input | 1 | 1 = unmasked, 0 = masked by register 0 |
| lmulLog2 | input | 2 | log2 of the group multiplier |
| sewCode | input | 2 | Element width code (8 << code bits) |
| unitOn | input | 1 | Vector unit enabled |
| opClass | input | 2 | 0 wide/single, 1 wide/wide, 2 narrow, 3 reserved |
| vs1IsVec | input | 1 | First source is a vector register |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outIllegal | output | 1 | Candidate is illegal |

## Verification
The bench targets several corner cases, each tied to a specific design error:
- **Groups ending at register 32.** A 5-bit bound would wrap to 0, so a design with that bug would report no overlap for two groups that really collide.
- **Unequal group sizes.** A design that sized the destination with L instead of 2·L would miss partial collisions.
- **Class 1 with coinciding destination and second source.** This must stay legal. A design that reused the class 0 overlap rule would reject it.
- **Masked register 0 in the narrowing class.** This is forbidden only when L > 1. The bench sets L = 1 and L = 2 with register 0 masked.
- **First-source checks.** The bench toggles `vs1IsVec` with a bad `rs1Idx`. A design that ignored the flag would flag instructions whose first source is a scalar.

// File: rtl/vwn_pkg.sv
package vwn_pkg;

  localparam int REG_IDX_W = 5;
  localparam int BOUND_W   = REG_IDX_W + 1;

  typedef enum logic [1:0] {
    CLS_WIDE_SS = 2'd0,
    CLS_WIDE_WS = 2'd1,
    CLS_NARROW  = 2'd2,
    CLS_RSVD    = 2'd3
  } opClass_e;

  typedef struct packed {
    logic capture;
    logic drop;
  } ctrlStrobe_t;

  function automatic logic groupsCollide(
    input logic [BOUND_W-1:0] aBase, input logic [BOUND_W-1:0] aSize,
    input logic [BOUND_W-1:0] bBase, input logic [BOUND_W-1:0] bSize);
    groupsCollide = (aBase < (bBase + bSize)) && (bBase < (aBase + aSize));
  endfunction

endpackage

// File: rtl/vwn_ctrl.sv
module vwn_ctrl
  import vwn_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output ctrlStrobe_t strb,
  output logic        outValid
);

  always_comb begin
    strb.capture = inValid & ~rst;
    strb.drop    = ~inValid | rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/vwn_datapath.sv
module vwn_datapath
  import vwn_pkg::*;
#(
  parameter int ELEN = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          strb,
  input  logic [REG_IDX_W-1:0] rdIdx,
  input  logic [REG_IDX_W-1:0] rs1Idx,
  input  logic [REG_IDX_W-1:0] rs2Idx,
  input  logic                 unmasked,
  input  logic [1:0]           lmulLog2,
  input  logic [1:0]           sewCode,
  input  logic                 unitOn,
  input  logic [1:0]           opClass,
  input  logic                 vs1IsVec,
  output logic                 outIllegal
);

  localparam int SEW_W = 9;

  logic [BOUND_W-1:0]   grpOne, grpTwo;
  logic [REG_IDX_W-1:0] maskOne, maskTwo;
  logic [BOUND_W-1:0]   rdB, rs1B, rs2B;
  logic [SEW_W-1:0]     dblSew;
  logic commonBad;
  logic rdAlTwoBad, rdAlOneBad, rs1AlOneBad, rs2AlOneBad, rs2AlTwoBad;
  logic wideRs2Hit, wideRs1Hit, narrowRs2Hit;
  logic wideBad, wideWsBad, narrowBad, illegalNext;

  always_comb begin
    grpOne  = BOUND_W'(1) << lmulLog2;
    grpTwo  = grpOne << 1;
    maskOne = REG_IDX_W'(grpOne - BOUND_W'(1));
    maskTwo = REG_IDX_W'(grpTwo - BOUND_W'(1));
    rdB     = {1'b0, rdIdx};
    rs1B    = {1'b0, rs1Idx};
    rs2B    = {1'b0, rs2Idx};
    dblSew  = SEW_W'(16) << sewCode;

    commonBad = ~unitOn || (lmulLog2 == 2'd3) || (int'(dblSew) > ELEN);

    rdAlTwoBad  = (rdIdx  & maskTwo) != '0;
    rdAlOneBad  = (rdIdx  & maskOne) != '0;
    rs1AlOneBad = (rs1Idx & maskOne) != '0;
    rs2AlOneBad = (rs2Idx & maskOne) != '0;
    rs2AlTwoBad = (rs2Idx & maskTwo) != '0;

    wideRs2Hit   = groupsCollide(rdB, grpTwo, rs2B, grpOne);
    wideRs1Hit   = groupsCollide(rdB, grpTwo, rs1B, grpOne);
    narrowRs2Hit = groupsCollide(rdB, grpOne, rs2B, grpTwo);

    wideBad   = rdAlTwoBad || (~unmasked && rdIdx == '0);
    wideWsBad = vs1IsVec && (rs1AlOneBad || wideRs1Hit);
    narrowBad = rs2AlTwoBad || rdAlOneBad || narrowRs2Hit
             || (~unmasked && lmulLog2 != 2'd0 && rdIdx == '0)
             || (vs1IsVec && rs1AlOneBad);

    unique case (opClass_e'(opClass))
      CLS_WIDE_SS: illegalNext = commonBad || wideBad || wideRs2Hit
                                 || rs2AlOneBad || wideWsBad;
      CLS_WIDE_WS: illegalNext = commonBad || wideBad || rs2AlTwoBad
                                 || wideWsBad;
      CLS_NARROW:  illegalNext = commonBad || narrowBad;
      default:     illegalNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              outIllegal <= 1'b0;
    else if (strb.capture) outIllegal <= illegalNext;
    else if (strb.drop)   outIllegal <= 1'b0;
  end

  assert_unit_off_R1: assert property (@(posedge clk) disable iff (rst)
    (strb.capture && !unitOn) |=> outIllegal);
  assert_lmul_cap_R1: assert property (@(posedge clk) disable iff (rst)
    (strb.capture && lmulLog2 == 2'd3) |=> outIllegal);
  assert_masked_v0_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.capture && opClass < 2'd2 && !unmasked && rdIdx == '0) |=> outIllegal);
  assert_reserved_cls_R10: assert property (@(posedge clk) disable iff (rst)
    (strb.capture && opClass == 2'd3) |=> outIllegal);
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> !outIllegal);

endmodule

// File: rtl/vwn_legality_check.sv
module vwn_legality_check
  import vwn_pkg::*;
#(
  parameter int ELEN = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [4:0] rdIdx,
  input  logic [4:0] rs1Idx,
  input  logic [4:0] rs2Idx,
  input  logic       unmasked,
  input  logic [1:0] lmulLog2,
  input  logic [1:0] sewCode,
  input  logic       unitOn,
  input  logic [1:0] opClass,
  input  logic       vs1IsVec,
  output logic       outValid,
  output logic       outIllegal
);

  ctrlStrobe_t strb;

  vwn_ctrl i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .strb(strb), .outValid(outValid)
  );

  vwn_datapath #(.ELEN(ELEN)) i_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .rdIdx(rdIdx), .rs1Idx(rs1Idx), .rs2Idx(rs2Idx), .unmasked(unmasked),
    .lmulLog2(lmulLog2), .sewCode(sewCode), .unitOn(unitOn),
    .opClass(opClass), .vs1IsVec(vs1IsVec), .outIllegal(outIllegal)
  );

endmodule

// File: tb/test_vwn_legality_check.sv
`timescale 1ns/1ps
module test_vwn_legality_check;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [4:0] rdIdx = '0, rs1Idx = '0, rs2Idx = '0;
  logic unmasked = 1'b1;
  logic [1:0] lmulLog2 = '0, sewCode = '0, opClass = '0;
  logic unitOn = 1'b1, vs1IsVec = 1'b0;
  logic outValid, outIllegal;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  vwn_legality_check i_vwn_legality_check (
    .clk(clk), .rst(rst), .inValid(inValid), .rdIdx(rdIdx), .rs1Idx(rs1Idx),
    .rs2Idx(rs2Idx), .unmasked(unmasked), .lmulLog2(lmulLog2), .sewCode(sewCode),
    .unitOn(unitOn), .opClass(opClass), .vs1IsVec(vs1IsVec),
    .outValid(outValid), .outIllegal(outIllegal)
  );

  function automatic bit hit(int a, int na, int b, int nb);
    return (a < b + nb) && (b < a + na);
  endfunction

  function automatic bit refIllegal(int cls, int rd, int r1, int r2, bit um,
                                    int lg, int sew, bit on, bit v1);
    int l = 1 << lg;
    int d = 2 * l;
    bit bad = 0;
    if (!on || lg == 3 || (16 << sew) > 64) return 1;
    case (cls)
      0: begin
        bad = (rd % d != 0) || (!um && rd == 0) || hit(rd, d, r2, l) || (r2 % l != 0);
        if (v1) bad |= hit(rd, d, r1, l) || (r1 % l != 0);
      end
      1: begin
        bad = (rd % d != 0) || (!um && rd == 0) || (r2 % d != 0);
        if (v1) bad |= hit(rd, d, r1, l) || (r1 % l != 0);
      end
      2: begin
        bad = (r2 % d != 0) || (rd % l != 0) || (!um && l > 1 && rd == 0) || hit(rd, l, r2, d);
        if (v1) bad |= (r1 % l != 0);
      end
      default: bad = 1;
    endcase
    return bad;
  endfunction

  task automatic check(string req, bit expV, bit expI);
    testCnt++;
    if (outValid !== expV || outIllegal !== expI) begin
      failCnt++;
      $display("FAIL %s: got valid=%b illegal=%b, expected valid=%b illegal=%b",
               req, outValid, outIllegal, expV, expI);
    end
  endtask

  task automatic apply(string req, int cls, int rd, int r1, int r2, bit um,
                       int lg, int sew, bit on, bit v1, bit expI);
    @(negedge clk);
    inValid = 1'b1; opClass = 2'(cls); rdIdx = 5'(rd); rs1Idx = 5'(r1);
    rs2Idx = 5'(r2); unmasked = um; lmulLog2 = 2'(lg); sewCode = 2'(sew);
    unitOn = on; vs1IsVec = v1;
    @(posedge clk); #1;
    check(req, 1'b1, expI);
    if (expI != refIllegal(cls, rd, r1, r2, um, lg, sew, on, v1))
      $display("note: directed expectation differs from model for %s", req);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); #1;
    check(req, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset", 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R1 common conditions
    apply("R1 unit off",   0, 2, 5, 4, 1, 0, 0, 0, 0, 1);
    apply("R5 legal base", 0, 2, 5, 4, 1, 0, 0, 1, 0, 0);
    apply("R1 lmul 8",     0, 0, 0, 16, 1, 3, 0, 1, 0, 1);
    apply("R1 sew 64",     0, 2, 5, 4, 1, 0, 3, 1, 0, 1);
    apply("R1 sew 32",     0, 2, 5, 4, 1, 0, 2, 1, 0, 0);
    idle("R2 idle");
    // R3 / R4
    apply("R3 rd misalign", 0, 2, 0, 8, 1, 1, 0, 1, 0, 1);
    apply("R3 rd aligned",  0, 4, 0, 8, 1, 1, 0, 1, 0, 0);
    apply("R4 masked v0",   0, 0, 0, 4, 0, 0, 0, 1, 0, 1);
    apply("R4 masked v2",   0, 2, 0, 4, 0, 0, 0, 1, 0, 0);
    apply("R4 class1 v0",   1, 0, 0, 8, 0, 1, 0, 1, 0, 1);
    // R5 / R6
    apply("R5 rs2 overlap", 0, 2, 0, 3, 1, 0, 0, 1, 0, 1);
    apply("R5 rs2 misalign",0, 4, 0, 9, 1, 1, 0, 1, 0, 1);
    apply("R6 rs1 overlap", 0, 2, 2, 4, 1, 0, 0, 1, 1, 1);
    apply("R6 rs1 scalar",  0, 2, 2, 4, 1, 0, 0, 1, 0, 0);
    apply("R6 rs1 misalign",0, 4, 11, 8, 1, 1, 0, 1, 1, 1);
    // R7
    apply("R7 rs2 misalign",1, 4, 0, 10, 1, 1, 0, 1, 0, 1);
    apply("R7 rs2 aligned", 1, 4, 0, 8, 1, 1, 0, 1, 0, 0);
    apply("R7 rs2 same grp",1, 4, 0, 4, 1, 1, 0, 1, 0, 0);
    apply("R7 rs1 overlap", 1, 4, 6, 8, 1, 1, 0, 1, 1, 1);
    apply("R7 rs1 misalign",1, 4, 3, 8, 1, 1, 0, 1, 1, 1);
    // R8 / R9
    apply("R8 rs2 misalign",2, 2, 0, 6, 1, 1, 0, 1, 0, 1);
    apply("R8 rd misalign", 2, 3, 0, 8, 1, 1, 0, 1, 0, 1);
    apply("R8 legal",       2, 2, 0, 8, 1, 1, 0, 1, 0, 0);
    apply("R8 masked v0 L2",2, 0, 0, 4, 0, 1, 0, 1, 0, 1);
    apply("R8 masked v0 L1",2, 0, 0, 4, 0, 0, 0, 1, 0, 0);
    apply("R9 overlap",     2, 4, 0, 4, 1, 1, 0, 1, 0, 1);
    apply("R9 rs1 misalign",2, 2, 5, 8, 1, 1, 0, 1, 1, 1);
    // R10
    apply("R10 reserved",   3, 4, 0, 8, 1, 0, 0, 1, 0, 1);
    // R11
    apply("R11 wide top",   0, 24, 0, 28, 1, 2, 0, 1, 0, 1);
    apply("R11 wide clear", 0, 16, 0, 28, 1, 2, 0, 1, 0, 0);
    apply("R11 narrow clr", 2, 20, 0, 24, 1, 2, 0, 1, 0, 0);
    apply("R11 narrow top", 2, 28, 0, 24, 1, 2, 0, 1, 0, 1);
    idle("R2 idle after");

    // Model comparison on every clock with mixed stimulus
    for (int n = 0; n < 3000; n++) begin
      int cls = $urandom_range(3, 0);
      int rd  = $urandom_range(31, 0);
      int r1  = $urandom_range(31, 0);
      int r2  = $urandom_range(31, 0);
      bit um  = 1'($urandom_range(1, 0));
      int lg  = $urandom_range(3, 0);
      int sw  = $urandom_range(3, 0);
      bit on  = ($urandom_range(15, 0) != 0);
      bit v1  = 1'($urandom_range(1, 0));
      bit go  = ($urandom_range(7, 0) != 0);
      @(negedge clk);
      inValid = go; opClass = 2'(cls); rdIdx = 5'(rd); rs1Idx = 5'(r1);
      rs2Idx = 5'(r2); unmasked = um; lmulLog2 = 2'(lg); sewCode = 2'(sw);
      unitOn = on; vs1IsVec = v1;
      @(posedge clk); #1;
      check("MODEL", go, go ? refIllegal(cls, rd, r1, r2, um, lg, sw, on, v1) : 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule